// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block controls a set of general-purpose pins split into two banks. Pins below a configurable split index belong to the core bank. Pins at or above it belong to the resume bank, where they are renumbered from zero. Both banks expose the same set of eight byte-addressed registers. A single-cycle register bus writes these registers and reads them back combinationally.

Each pin can be enabled or disabled, and set as an input or an output. Its level register drives the pin when it is an output, and reports the synchronized pad value when it is an input. Each pin can latch rising edges, falling edges or both into a sticky status bit, which software clears by writing 1. A single level-sensitive event line is high while any status bit whose event enable is set is pending. An eighth register per bank is plain storage for an auxiliary routing enable consumed outside this block.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After a synchronous reset, every implemented direction bit reads 1 (input), and every other register bit reads 0. `pin_oe` is all zero and `event_o` is 0.
- R2: The address fields are as follows. Bit 5 selects the bank (0 core, 1 resume). Bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 event enable, 6 auxiliary enable, 7 status. Bits 1:0 select the byte lane. Bank-local pin n sits in lane n/8 at bit n mod 8. Pin p maps to the resume bank at local index p - RESUME_BASE when p >= RESUME_BASE. Bits with no pin behind them read 0 and ignore writes.
- R3: `pin_oe[p]` is 1 exactly when the pin is enabled and its direction bit is 0. `pin_out[p]` carries the pin's level register.
- R4: A level write to a pin whose direction bit is 1 leaves its driven value unchanged. A level read returns the synchronized input for input pins and the driven value for output pins.
- R5: Inputs pass through two flops. An input change first sampled at clock edge k sets its status bit at edge k+2, and it is visible on reads right after that edge.
- R6: Rising and falling capture are enabled independently. A transition whose direction is not enabled leaves the status bit clear.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A captured edge in the same cycle as a clear leaves the bit set.
- R8: `event_o` is high while any pin has both its status bit and its event enable set. Clearing an event enable masks the pin without clearing its status.
- R9: A pin whose enable bit is 0 never drives (`pin_oe` 0), and its edges do not set its status.
- R10: The enable, direction, rising, falling, event and auxiliary registers read back the last value written to each implemented bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte address (bank, register, lane) |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Raw pad inputs |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin driven value |
| event_o | output | 1 | Level event, any enabled pending status |

## Verification
The hardest case to reach is a status clear landing in the exact cycle that a new edge is captured on the same pin. That requires the bus write and the two-flop synchronizer delay to line up to the cycle. The stimulus first sets a status bit. It then reverses the pin with both edge enables set, waits exactly two cycles, and issues the clearing write so that it coincides with the capture. A long seeded random phase follows. It mixes pin toggles with writes to random addresses, including unimplemented lanes and status clears. Every cycle it is compared with a bench model built from the requirements.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int LANE_W    = 8;
    localparam int LANES     = 4;
    localparam int BANK_MAXP = LANE_W * LANES;

    typedef enum logic [2:0] {
        RK_ENABLE = 3'd0,
        RK_DIR    = 3'd1,
        RK_LEVEL  = 3'd2,
        RK_RISE   = 3'd3,
        RK_FALL   = 3'd4,
        RK_EVENT  = 3'd5,
        RK_AUX    = 3'd6,
        RK_STATUS = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      bank;
        reg_kind_e kind;
        logic [1:0] lane;
    } addr_fields_t;

    typedef struct packed {
        logic       wr;
        reg_kind_e  kind;
        logic [1:0] lane;
        logic [7:0] data;
    } bank_req_t;

    function automatic addr_fields_t split_addr(input logic [5:0] a);
        return addr_fields_t'(a);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;

    // Edge detection relies on prev being exactly one sample behind cur (R5)
    assert_prev_follows_R5: assert property (@(posedge clk) disable iff (rst)
        prev_q == $past(cur_q));

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_bank_pkg::*;
#(
    parameter int BANK_PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bank_req_t            req,
    input  logic [BANK_PINS-1:0] s_cur,
    input  logic [BANK_PINS-1:0] s_prev,
    output logic [7:0]           rdata,
    output logic [BANK_PINS-1:0] oe,
    output logic [BANK_PINS-1:0] dout,
    output logic                 evt
);
    localparam int P = BANK_PINS;

    logic [P-1:0] en, dir, lvl, rise, fall, evt_en, aux, sts;
    logic [P-1:0] n_en, n_dir, n_lvl, n_rise, n_fall, n_evt, n_aux, n_sts;
    logic [P-1:0] lane_sel, wbit, clr, edge_hit;
    logic [BANK_MAXP-1:0] word;

    always_comb begin
        for (int i = 0; i < P; i++) begin
            lane_sel[i] = req.wr && (req.lane == 2'(i / LANE_W));
            wbit[i]     = req.data[i % LANE_W];
        end
        edge_hit = en & ((s_cur & ~s_prev & rise) | (~s_cur & s_prev & fall));
        n_en  = en;
        n_dir = dir;
        n_lvl = lvl;
        n_rise = rise;
        n_fall = fall;
        n_evt = evt_en;
        n_aux = aux;
        clr   = '0;
        case (req.kind)
            RK_ENABLE: n_en   = (en & ~lane_sel) | (wbit & lane_sel);
            RK_DIR:    n_dir  = (dir & ~lane_sel) | (wbit & lane_sel);
            RK_LEVEL:  n_lvl  = (lvl & ~(lane_sel & ~dir)) | (wbit & lane_sel & ~dir);
            RK_RISE:   n_rise = (rise & ~lane_sel) | (wbit & lane_sel);
            RK_FALL:   n_fall = (fall & ~lane_sel) | (wbit & lane_sel);
            RK_EVENT:  n_evt  = (evt_en & ~lane_sel) | (wbit & lane_sel);
            RK_AUX:    n_aux  = (aux & ~lane_sel) | (wbit & lane_sel);
            RK_STATUS: clr    = lane_sel & wbit;
        endcase
        n_sts = edge_hit | (sts & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= '0;
            dir    <= '1;
            lvl    <= '0;
            rise   <= '0;
            fall   <= '0;
            evt_en <= '0;
            aux    <= '0;
            sts    <= '0;
        end else begin
            en     <= n_en;
            dir    <= n_dir;
            lvl    <= n_lvl;
            rise   <= n_rise;
            fall   <= n_fall;
            evt_en <= n_evt;
            aux    <= n_aux;
            sts    <= n_sts;
        end
    end

    always_comb begin
        case (req.kind)
            RK_ENABLE: word = BANK_MAXP'(en);
            RK_DIR:    word = BANK_MAXP'(dir);
            RK_LEVEL:  word = BANK_MAXP'((dir & s_cur) | (~dir & lvl));
            RK_RISE:   word = BANK_MAXP'(rise);
            RK_FALL:   word = BANK_MAXP'(fall);
            RK_EVENT:  word = BANK_MAXP'(evt_en);
            RK_AUX:    word = BANK_MAXP'(aux);
            RK_STATUS: word = BANK_MAXP'(sts);
        endcase
        rdata = word[{req.lane, 3'b000} +: LANE_W];
    end

    assign oe   = en & ~dir;
    assign dout = lvl;
    assign evt  = |(sts & evt_en);

    for (genvar i = 0; i < P; i++) begin : g_chk
        // Level writes to an input pin are dropped (R4)
        assert_level_locked_R4: assert property (@(posedge clk) disable iff (rst)
            (lane_sel[i] && req.kind == RK_LEVEL && dir[i]) |=> $stable(lvl[i]));
        // A status bit only rises because an enabled edge was detected (R6)
        assert_status_cause_R6: assert property (@(posedge clk) disable iff (rst)
            !edge_hit[i] |=> !$rose(sts[i]));
        // A captured edge always lands, even against a clear (R7)
        assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
            edge_hit[i] |=> sts[i]);
        // Without a clear, a set status bit stays set (R7)
        assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            (sts[i] && !clr[i]) |=> sts[i]);
        // A disabled pin captures nothing (R9)
        assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            (!en[i] && !sts[i]) |=> !sts[i]);
    end

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int RESUME_BASE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [5:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_we,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                event_o
);
    localparam int NUM_BANKS = 2;

    addr_fields_t af;
    logic [NUM_PINS-1:0] s_cur, s_prev;
    logic [7:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_evt;

    assign af = split_addr(bus_addr);

    gpio_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_in),
        .cur     (s_cur),
        .prev    (s_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = (b == 0) ? 0 : RESUME_BASE;
        localparam int W  = (b == 0) ? RESUME_BASE : NUM_PINS - RESUME_BASE;

        bank_req_t    req;
        logic [W-1:0] oe_w, dout_w;

        assign req.wr   = bus_we && (af.bank == 1'(b));
        assign req.kind = af.kind;
        assign req.lane = af.lane;
        assign req.data = bus_wdata;

        gpio_reg_bank #(.BANK_PINS(W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .s_cur  (s_cur[LO +: W]),
            .s_prev (s_prev[LO +: W]),
            .rdata  (bank_rd[b]),
            .oe     (oe_w),
            .dout   (dout_w),
            .evt    (bank_evt[b])
        );

        assign pin_oe[LO +: W]  = oe_w;
        assign pin_out[LO +: W] = dout_w;
    end

    assign bus_rdata = bank_rd[af.bank];
    assign event_o   = |bank_evt;

    // No pin drives in the cycle after reset (R1)
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && !event_o));

endmodule

// File: tb/gpio_banked_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_bench;
    localparam int NP = 24;
    localparam int RB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe, pin_out;
    logic event_o;

    always #2.5 clk = ~clk;

    gpio_banked_ctrl #(.NUM_PINS(NP), .RESUME_BASE(RB)) u_gpio_banked_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .event_o(event_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NP-1:0] m_en, m_dir, m_lvl, m_rise, m_fall, m_evt, m_aux, m_sts;
    logic [NP-1:0] m_s1, m_cur, m_prev;

    task automatic model_reset();
        m_en = '0; m_dir = '1; m_lvl = '0; m_rise = '0; m_fall = '0;
        m_evt = '0; m_aux = '0; m_sts = '0; m_s1 = '0; m_cur = '0; m_prev = '0;
    endtask

    function automatic int pin_addr(int p, int kind);
        int bk = (p >= RB) ? 1 : 0;
        int loc = p - (bk ? RB : 0);
        return bk * 32 + kind * 4 + loc / 8;
    endfunction

    function automatic int pin_bit(int p);
        return (p >= RB) ? (p - RB) % 8 : p % 8;
    endfunction

    function automatic logic [7:0] exp_read(logic [5:0] a);
        logic [7:0] r = '0;
        int bk = int'(a[5]);
        int width = bk ? NP - RB : RB;
        int base = bk ? RB : 0;
        for (int b = 0; b < 8; b++) begin
            int loc = int'(a[1:0]) * 8 + b;
            if (loc < width) begin
                int g = base + loc;
                case (a[4:2])
                    3'd0: r[b] = m_en[g];
                    3'd1: r[b] = m_dir[g];
                    3'd2: r[b] = m_dir[g] ? m_cur[g] : m_lvl[g];
                    3'd3: r[b] = m_rise[g];
                    3'd4: r[b] = m_fall[g];
                    3'd5: r[b] = m_evt[g];
                    3'd6: r[b] = m_aux[g];
                    default: r[b] = m_sts[g];
                endcase
            end
        end
        return r;
    endfunction

    task automatic model_step();
        logic [NP-1:0] hit, clr;
        hit = m_en & ((m_cur & ~m_prev & m_rise) | (~m_cur & m_prev & m_fall));
        clr = '0;
        if (bus_we) begin
            for (int g = 0; g < NP; g++) begin
                int bk = (g >= RB) ? 1 : 0;
                int loc = g - (bk ? RB : 0);
                if (bus_addr[5] == 1'(bk) && int'(bus_addr[1:0]) == loc / 8) begin
                    logic bt = bus_wdata[loc % 8];
                    case (bus_addr[4:2])
                        3'd0: m_en[g] = bt;
                        3'd1: m_dir[g] = bt;
                        3'd2: if (!m_dir[g]) m_lvl[g] = bt;
                        3'd3: m_rise[g] = bt;
                        3'd4: m_fall[g] = bt;
                        3'd5: m_evt[g] = bt;
                        3'd6: m_aux[g] = bt;
                        default: clr[g] = bt;
                    endcase
                end
            end
        end
        m_sts = hit | (m_sts & ~clr);
        m_prev = m_cur;
        m_cur = m_s1;
        m_s1 = pin_in;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(logic [5:0] a, string tag);
        bus_addr = a;
        #1;
        chk(32'(bus_rdata), 32'(exp_read(a)), tag);
    endtask

    task automatic state_chk(string tag);
        chk(32'(pin_oe), 32'(m_en & ~m_dir), {tag, " oe"});
        chk(32'(pin_out), 32'(m_lvl), {tag, " out"});
        chk(32'(event_o), 32'(|(m_sts & m_evt)), {tag, " event"});
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic set_bit(int p, int kind, logic v);
        logic [5:0] a = 6'(pin_addr(p, kind));
        logic [7:0] d = exp_read(a);
        if (kind == 7) d = '0;
        d[pin_bit(p)] = v;
        wr(a, d);
    endtask

    function automatic logic sts_of(int p);
        return m_sts[p];
    endfunction

    task automatic sts_chk(int p, logic exp, string tag);
        logic [5:0] a = 6'(pin_addr(p, 7));
        bus_addr = a;
        #1;
        chk(32'(bus_rdata[pin_bit(p)]), 32'(exp), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state across the whole address space
        for (int a = 0; a < 64; a++) rd_chk(6'(a), "R1 reset read");
        state_chk("R1 reset");

        // R10 / R2: round trips, including an unimplemented lane
        wr(6'h00, 8'hA5); rd_chk(6'h00, "R10 enable lane0");
        wr(6'h19, 8'h3C); rd_chk(6'h19, "R10 aux core lane1");
        wr(6'h22, 8'hFF); rd_chk(6'h22, "R2 unimplemented lane");
        wr(6'h34, 8'h0F); rd_chk(6'h34, "R2 resume event lane0");
        wr(6'h00, 8'h00); wr(6'h34, 8'h00);

        // R3: pin 3 as enabled output driving 1
        set_bit(3, 0, 1'b1); set_bit(3, 1, 1'b0); set_bit(3, 2, 1'b1);
        chk(32'(pin_oe[3]), 32'd1, "R3 oe pin3");
        chk(32'(pin_out[3]), 32'd1, "R3 out pin3");
        state_chk("R3");

        // R9: pin 4 output direction but disabled
        set_bit(4, 1, 1'b0);
        chk(32'(pin_oe[4]), 32'd0, "R9 disabled no drive");

        // R4: level write on input pin 5 ignored; reads sampled input
        set_bit(5, 2, 1'b1);
        chk(32'(pin_out[5]), 32'd0, "R4 input level write ignored");
        rd_chk(6'(pin_addr(5, 2)), "R4 level read input low");
        pin_in[5] = 1'b1;
        repeat (3) tick();
        rd_chk(6'(pin_addr(5, 2)), "R4 level read input high");
        bus_addr = 6'(pin_addr(5, 2)); #1;
        chk(32'(bus_rdata[5]), 32'd1, "R4 level shows pad");

        // R5: capture latency on resume pin 17 (rising)
        set_bit(17, 0, 1'b1); set_bit(17, 3, 1'b1);
        pin_in[17] = 1'b1;
        tick(); sts_chk(17, 1'b0, "R5 after edge k");
        tick(); sts_chk(17, 1'b0, "R5 after edge k+1");
        tick(); sts_chk(17, 1'b1, "R5 after edge k+2");

        // R6: falling-only pin 18 ignores rising
        set_bit(18, 0, 1'b1); set_bit(18, 4, 1'b1);
        pin_in[18] = 1'b1; repeat (3) tick();
        sts_chk(18, 1'b0, "R6 rising ignored");
        pin_in[18] = 1'b0; repeat (3) tick();
        sts_chk(18, 1'b1, "R6 falling captured");

        // R7: write 0 no effect, write 1 clears, edge beats clear
        wr(6'(pin_addr(17, 7)), 8'h00); sts_chk(17, 1'b1, "R7 zero write");
        set_bit(17, 4, 1'b1);
        pin_in[17] = 1'b0;
        tick(); tick();
        wr(6'(pin_addr(17, 7)), 8'h02);
        sts_chk(17, 1'b1, "R7 edge wins over clear");
        wr(6'(pin_addr(17, 7)), 8'h02);
        sts_chk(17, 1'b0, "R7 clear");

        // R8: event gating and masking
        pin_in[17] = 1'b1; repeat (3) tick();
        chk(32'(event_o), 32'd0, "R8 status without enable");
        set_bit(17, 5, 1'b1);
        chk(32'(event_o), 32'd1, "R8 event raised");
        set_bit(17, 5, 1'b0);
        chk(32'(event_o), 32'd0, "R8 masked");
        sts_chk(17, 1'b1, "R8 mask keeps status");
        set_bit(17, 5, 1'b1);
        chk(32'(event_o), 32'd1, "R8 unmasked");

        // R9: disabled pin 20 captures nothing
        set_bit(20, 3, 1'b1); set_bit(20, 4, 1'b1);
        pin_in[20] = 1'b1; repeat (3) tick();
        pin_in[20] = 1'b0; repeat (3) tick();
        sts_chk(20, 1'b0, "R9 disabled no capture");

        // Random phase
        void'($urandom(32'd4242));
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < NP; p++)
                if ($urandom_range(0, 9) == 0) pin_in[p] = ~pin_in[p];
            if ($urandom_range(0, 2) == 0) begin
                bus_addr = 6'($urandom);
                bus_wdata = 8'($urandom);
                bus_we = 1'b1;
            end
            tick();
            bus_we = 1'b0;
            state_chk("R8 random");
            rd_chk(6'($urandom), "R2 random read");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule